// File: doc/BRIEF.md
# In-Memory Bulk Row Copy Sequencer

This block sits on the controller side of a DRAM channel. It turns bulk requests into DRAM command sequences so that data moves inside the memory and never crosses the channel. A request is one of three kinds. A copy names a source row and a destination row. A zero request names a destination row. A fill names a destination row, a byte value and a number of extra rows.

For a copy, the engine compares the bank and subarray of the source with those of the destination and picks one of three plans:

- **Same bank and same subarray:** two back-to-back activates move the whole row through the shared sense amplifiers.
- **Different banks:** a pipelined column-by-column stream runs over the bank-shared bus.
- **Same bank, different subarrays:** two such streams run in sequence through a scratch row in the neighbouring bank.

A zero request reuses the two-activate plan from a reserved all-zero row. A fill first writes the value into one row and then replicates that row into the following rows with further activates. A bank model answers each read with data one cycle later on `rd_data`.

Top module: `bulk_row_mover`

## Requirements
- R1: A copy (kind 0) whose source and destination share bank and subarray issues ACT(1) source row, ACT destination row, PRE(2) of that subarray, and no read or write. The destination row then holds the source contents, and `done` rises 4 cycles after acceptance.
- R2: A copy between different banks issues ACT source, ACT destination, a READ(3) of every column 0..COLS-1 in order, a write-lane write of every column, then PRE source and PRE destination. `done` rises COLS+6 cycles after acceptance.
- R3: A copy between different subarrays of one bank performs two R2 streams. The first goes into row SCRATCH_ROW of bank (destination bank XOR 1), destination subarray. The second goes from there into the destination. Both rows end with the source data, and `done` rises 2*COLS+11 cycles after acceptance.
- R4: A zero request (kind 1) issues ACT of row ZERO_ROW in the destination subarray, ACT destination, PRE, and no column traffic. The destination reads all zero afterwards, and `done` rises 4 cycles after acceptance.
- R5: A fill (kind 2) with count N issues ACT destination, writes the value into every column, then issues ACT on rows destination+1..destination+N, then one PRE. Rows destination..destination+N hold the value, and `done` rises COLS+N+3 cycles after acceptance.
- R6: A copy whose source equals its destination issues no command and raises `done` 1 cycle after acceptance. A request of kind 3 behaves the same way.
- R7: `req_ready` is high exactly when the engine is idle, including after reset. A request offered while the engine is busy is ignored and leaves memory and command counts unchanged.
- R8: `done` is a single-cycle pulse. It comes in the cycle after the final PRE, and no command is issued in that cycle.
- R9: In a stream, the READ of column i+1 goes out in the same cycle as the write of column i, with write data taken from `rd_data`. There are exactly COLS-1 such paired cycles per stream, and the write lane is never active together with an ACT or PRE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken when valid |
| req_kind | input | 2 | 0 copy, 1 zero, 2 fill, 3 none |
| req_src_bank | input | BW | Source bank |
| req_src_sa | input | SW | Source subarray |
| req_src_row | input | RW | Source row within subarray |
| req_dst_bank | input | BW | Destination bank |
| req_dst_sa | input | SW | Destination subarray |
| req_dst_row | input | RW | Destination row within subarray |
| req_count | input | RW | Fill: extra rows after the first |
| req_value | input | DATA_W | Fill byte value |
| done | output | 1 | Completion pulse |
| cmd_valid | output | 1 | Command lane active |
| cmd_op | output | 2 | 1 ACT, 2 PRE, 3 READ |
| cmd_bank | output | BW | Command bank |
| cmd_sa | output | SW | Command subarray |
| cmd_row | output | RW | Row for ACT |
| cmd_col | output | CW | Column for READ |
| wr_en | output | 1 | Write lane active, into the open row |
| wr_bank | output | BW | Write bank |
| wr_sa | output | SW | Write subarray |
| wr_col | output | CW | Write column |
| wr_data | output | DATA_W | Write data |
| rd_data | input | DATA_W | Read data, valid the cycle after READ |

## Verification
During a stream, the command lane and the write lane are both busy in the same cycle. The READ of the next column goes out together with the write of the column whose data has just returned. The bench sweeps every source/destination bank and subarray pairing. It counts the cycles where a READ and a write coincide and compares that count against COLS-1 per stream. A bank model checks that every column access targets an open subarray, and the final contents of the whole memory are compared against an arithmetic model, so a write that is off by one column or one cycle shows up as a data mismatch.

// File: rtl/bulk_row_mover.sv
module bulk_row_mover #(
  parameter int BANKS       = 2,
  parameter int SUBARRAYS   = 2,
  parameter int ROWS        = 8,
  parameter int COLS        = 4,
  parameter int DATA_W      = 8,
  parameter int ZERO_ROW    = ROWS - 1,
  parameter int SCRATCH_ROW = ROWS - 2,
  localparam int BW = $clog2(BANKS),
  localparam int SW = $clog2(SUBARRAYS),
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [BW-1:0]     req_src_bank,
  input  logic [SW-1:0]     req_src_sa,
  input  logic [RW-1:0]     req_src_row,
  input  logic [BW-1:0]     req_dst_bank,
  input  logic [SW-1:0]     req_dst_sa,
  input  logic [RW-1:0]     req_dst_row,
  input  logic [RW-1:0]     req_count,
  input  logic [DATA_W-1:0] req_value,
  output logic              done,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BW-1:0]     cmd_bank,
  output logic [SW-1:0]     cmd_sa,
  output logic [RW-1:0]     cmd_row,
  output logic [CW-1:0]     cmd_col,
  output logic              wr_en,
  output logic [BW-1:0]     wr_bank,
  output logic [SW-1:0]     wr_sa,
  output logic [CW-1:0]     wr_col,
  output logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data
);
  localparam logic [1:0] OP_ACT = 2'd1;
  localparam logic [1:0] OP_PRE = 2'd2;
  localparam logic [1:0] OP_RD  = 2'd3;
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ACT_A, S_ACT_B, S_XFER, S_TAIL, S_PRE_A, S_PRE_B, S_FWR, S_FREP, S_DONE
  } state_t;
  typedef enum logic [1:0] { M_FPM, M_PSM, M_FILL } mode_t;

  state_t st;
  mode_t  mode;
  logic [BW-1:0] a_b, b_b, f_b;
  logic [SW-1:0] a_s, b_s, f_s;
  logic [RW-1:0] a_r, b_r, f_r, rep;
  logic [CW-1:0] col;
  logic [DATA_W-1:0] val;
  logic leg2;

  wire same_loc  = (req_src_bank == req_dst_bank) && (req_src_sa == req_dst_sa)
                   && (req_src_row == req_dst_row);
  wire same_bank = (req_src_bank == req_dst_bank);
  wire same_sa   = (req_src_sa == req_dst_sa);
  wire [BW-1:0] scr_bank = req_dst_bank ^ BW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  mode <= M_FPM;  leg2 <= 1'b0;
      a_b <= '0; a_s <= '0; a_r <= '0;
      b_b <= '0; b_s <= '0; b_r <= '0;
      f_b <= '0; f_s <= '0; f_r <= '0;
      col <= '0; rep <= '0; val <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          b_b <= req_dst_bank; b_s <= req_dst_sa; b_r <= req_dst_row;
          a_b <= req_src_bank; a_s <= req_src_sa; a_r <= req_src_row;
          f_b <= req_dst_bank; f_s <= req_dst_sa; f_r <= req_dst_row;
          leg2 <= 1'b0; rep <= req_count; val <= req_value; col <= '0;
          st <= S_ACT_A;
          case (req_kind)
            2'd0: begin
              if (same_loc) st <= S_DONE;
              else if (!same_bank) mode <= M_PSM;
              else if (same_sa) mode <= M_FPM;
              else begin
                mode <= M_PSM; leg2 <= 1'b1;
                b_b <= scr_bank; b_r <= RW'(SCRATCH_ROW);
              end
            end
            2'd1: begin
              mode <= M_FPM;
              a_b <= req_dst_bank; a_s <= req_dst_sa; a_r <= RW'(ZERO_ROW);
            end
            2'd2: begin
              mode <= M_FILL;
              a_b <= req_dst_bank; a_s <= req_dst_sa; a_r <= req_dst_row;
            end
            default: st <= S_DONE;
          endcase
        end
        S_ACT_A: begin
          col <= '0;
          st  <= (mode == M_FILL) ? S_FWR : S_ACT_B;
        end
        S_ACT_B: st <= (mode == M_FPM) ? S_PRE_B : S_XFER;
        S_XFER: begin
          if (col == LAST_COL) st <= S_TAIL;
          else col <= col + CW'(1);
        end
        S_TAIL:  st <= S_PRE_A;
        S_PRE_A: st <= S_PRE_B;
        S_PRE_B: begin
          if (leg2) begin
            leg2 <= 1'b0;
            a_b <= b_b; a_s <= b_s; a_r <= b_r;
            b_b <= f_b; b_s <= f_s; b_r <= f_r;
            st  <= S_ACT_A;
          end else st <= S_DONE;
        end
        S_FWR: begin
          if (col == LAST_COL) begin
            if (rep != '0) begin
              st <= S_FREP; b_r <= b_r + RW'(1);
            end else st <= S_PRE_B;
          end else col <= col + CW'(1);
        end
        S_FREP: begin
          rep <= rep - RW'(1);
          if (rep == RW'(1)) st <= S_PRE_B;
          else b_r <= b_r + RW'(1);
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire on_a = (st == S_ACT_A) || (st == S_XFER) || (st == S_PRE_A);

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign cmd_valid = (st == S_ACT_A) || (st == S_ACT_B) || (st == S_XFER) ||
                     (st == S_PRE_A) || (st == S_PRE_B) || (st == S_FREP);
  assign cmd_op    = (st == S_XFER) ? OP_RD :
                     ((st == S_PRE_A) || (st == S_PRE_B)) ? OP_PRE :
                     cmd_valid ? OP_ACT : 2'd0;
  assign cmd_bank  = on_a ? a_b : b_b;
  assign cmd_sa    = on_a ? a_s : b_s;
  assign cmd_row   = on_a ? a_r : b_r;
  assign cmd_col   = col;

  assign wr_en   = ((st == S_XFER) && (col != '0)) || (st == S_TAIL) || (st == S_FWR);
  assign wr_bank = b_b;
  assign wr_sa   = b_s;
  assign wr_col  = (st == S_XFER) ? col - CW'(1) : col;
  assign wr_data = (st == S_FWR) ? val : rd_data;
endmodule

// File: rtl/bulk_row_mover_chk.sv
module bulk_row_mover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       wr_en
);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_valid && !wr_en));

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_no_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && !wr_en && !req_ready));

  p_done_after_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cmd_valid)) |-> ($past(cmd_op) == 2'd2));

  p_write_lane_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_valid) |-> (cmd_op == 2'd3));
endmodule

bind bulk_row_mover bulk_row_mover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wr_en(wr_en)
);

// File: tb/bulk_row_mover_tb_top.sv
module bulk_row_mover_tb_top;
  localparam int NB = 2, NS = 2, NR = 8, C = 4, DW = 8;
  localparam int ZR = NR - 1, SR = NR - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready, done;
  logic [1:0] req_kind = '0;
  logic [0:0] req_src_bank = '0, req_src_sa = '0, req_dst_bank = '0, req_dst_sa = '0;
  logic [2:0] req_src_row = '0, req_dst_row = '0, req_count = '0;
  logic [DW-1:0] req_value = '0;
  logic cmd_valid, wr_en;
  logic [1:0] cmd_op, cmd_col, wr_col;
  logic [0:0] cmd_bank, cmd_sa, wr_bank, wr_sa;
  logic [2:0] cmd_row;
  logic [DW-1:0] wr_data, rd_data;

  bulk_row_mover dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src_bank(req_src_bank), .req_src_sa(req_src_sa),
    .req_src_row(req_src_row), .req_dst_bank(req_dst_bank), .req_dst_sa(req_dst_sa),
    .req_dst_row(req_dst_row), .req_count(req_count), .req_value(req_value),
    .done(done), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_sa(cmd_sa), .cmd_row(cmd_row), .cmd_col(cmd_col), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_sa(wr_sa), .wr_col(wr_col), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  logic [DW-1:0] mem [NB][NS][NR][C];
  logic [DW-1:0] rbuf [NB][NS][C];
  logic          opn  [NB][NS];
  logic [2:0]    orow [NB][NS];
  int n_act = 0, n_pre = 0, n_rd = 0, n_wr = 0, n_ovl = 0, n_err = 0;

  function automatic logic [DW-1:0] pat(int b, int s, int r, int c);
    return (r == ZR) ? '0 : DW'(b * 64 + s * 32 + r * 4 + c + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < NS; s++) begin
          opn[b][s] <= 1'b0; orow[b][s] <= '0;
          for (int c = 0; c < C; c++) rbuf[b][s][c] <= '0;
          for (int r = 0; r < NR; r++)
            for (int c = 0; c < C; c++) mem[b][s][r][c] <= pat(b, s, r, c);
        end
      rd_data <= '0;
    end else begin
      if (cmd_valid) begin
        case (cmd_op)
          2'd1: begin
            n_act++;
            if (opn[cmd_bank][cmd_sa])
              for (int c = 0; c < C; c++) mem[cmd_bank][cmd_sa][cmd_row][c] <= rbuf[cmd_bank][cmd_sa][c];
            else
              for (int c = 0; c < C; c++) rbuf[cmd_bank][cmd_sa][c] <= mem[cmd_bank][cmd_sa][cmd_row][c];
            opn[cmd_bank][cmd_sa] <= 1'b1;
            orow[cmd_bank][cmd_sa] <= cmd_row;
          end
          2'd2: begin n_pre++; opn[cmd_bank][cmd_sa] <= 1'b0; end
          2'd3: begin
            n_rd++;
            if (!opn[cmd_bank][cmd_sa]) n_err++;
            rd_data <= rbuf[cmd_bank][cmd_sa][cmd_col];
          end
          default: n_err++;
        endcase
      end
      if (wr_en) begin
        n_wr++;
        if (!opn[wr_bank][wr_sa]) n_err++;
        rbuf[wr_bank][wr_sa][wr_col] <= wr_data;
        mem[wr_bank][wr_sa][orow[wr_bank][wr_sa]][wr_col] <= wr_data;
        if (cmd_valid && cmd_op == 2'd3) n_ovl++;
      end
    end
  end

  logic [DW-1:0] ex [NB][NS][NR][C];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic run(input int kind, input int sb, input int ss, input int sr,
                     input int db, input int ds, input int dr, input int cnt,
                     input int v, input string rq, input bit inject);
    int lat, a0, p0, r0, w0, o0, e0, n, mism;
    int ea, ep, erd, ewr, eov;
    logic [DW-1:0] tmp [C];
    a0 = n_act; p0 = n_pre; r0 = n_rd; w0 = n_wr; o0 = n_ovl; e0 = n_err;
    ea = 0; ep = 0; erd = 0; ewr = 0; eov = 0; lat = 1;
    if (kind == 0) begin
      for (int c = 0; c < C; c++) tmp[c] = ex[sb][ss][sr][c];
      if (sb == db && ss == ds && sr == dr) lat = 1;
      else if (sb != db) begin
        lat = C + 6; ea = 2; ep = 2; erd = C; ewr = C; eov = C - 1;
      end else if (ss == ds) begin
        lat = 4; ea = 2; ep = 1;
      end else begin
        lat = 2 * C + 11; ea = 4; ep = 4; erd = 2 * C; ewr = 2 * C; eov = 2 * C - 2;
        for (int c = 0; c < C; c++) ex[db ^ 1][ds][SR][c] = tmp[c];
      end
      for (int c = 0; c < C; c++) ex[db][ds][dr][c] = tmp[c];
    end else if (kind == 1) begin
      lat = 4; ea = 2; ep = 1;
      for (int c = 0; c < C; c++) ex[db][ds][dr][c] = '0;
    end else if (kind == 2) begin
      lat = C + cnt + 3; ea = 1 + cnt; ep = 1; ewr = C;
      for (int r = dr; r <= dr + cnt; r++)
        for (int c = 0; c < C; c++) ex[db][ds][r][c] = DW'(v);
    end
    @(negedge clk);
    req_kind = 2'(kind); req_src_bank = 1'(sb); req_src_sa = 1'(ss); req_src_row = 3'(sr);
    req_dst_bank = 1'(db); req_dst_sa = 1'(ds); req_dst_row = 3'(dr);
    req_count = 3'(cnt); req_value = DW'(v); req_valid = 1'b1;
    @(posedge clk);
    n = 0;
    while (n < 200) begin
      @(negedge clk);
      n++;
      req_valid = 1'b0;
      if (inject && n == 3) begin
        chk(req_ready == 1'b0, "R7 ready low while busy", req_ready, 0);
        req_kind = 2'd2; req_dst_bank = 1'b0; req_dst_sa = 1'b0; req_dst_row = 3'd0;
        req_count = 3'd2; req_value = 8'hEE; req_valid = 1'b1;
      end
      if (done) break;
    end
    chk(n == lat, {rq, " latency"}, n, lat);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b0 && req_ready == 1'b1, "R8 done single pulse then idle", done, 0);
    chk(n_act - a0 == ea && n_pre - p0 == ep, {rq, " ACT/PRE count"}, (n_act - a0) * 100 + n_pre - p0, ea * 100 + ep);
    chk(n_rd - r0 == erd && n_wr - w0 == ewr, {rq, " READ/WRITE count"}, (n_rd - r0) * 100 + n_wr - w0, erd * 100 + ewr);
    chk(n_ovl - o0 == eov, "R9 paired read+write cycles", n_ovl - o0, eov);
    chk(n_err == e0, {rq, " column access to closed row"}, n_err - e0, 0);
    mism = 0;
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NS; s++)
        for (int r = 0; r < NR; r++)
          for (int c = 0; c < C; c++)
            if (mem[b][s][r][c] !== ex[b][s][r][c]) mism++;
    chk(mism == 0, {rq, " memory contents"}, mism, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NS; s++)
        for (int r = 0; r < NR; r++)
          for (int c = 0; c < C; c++) ex[b][s][r][c] = pat(b, s, r, c);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready after reset", req_ready, 1);
    chk(cmd_valid == 1'b0 && wr_en == 1'b0 && done == 1'b0, "R7 quiet after reset",
        {cmd_valid, wr_en, done}, 0);

    for (int sb = 0; sb < NB; sb++)
      for (int ss = 0; ss < NS; ss++)
        for (int db = 0; db < NB; db++)
          for (int ds = 0; ds < NS; ds++) begin
            if (sb != db) run(0, sb, ss, 1 + ss, db, ds, 3 + db, 0, 0, "R2 inter-bank copy", 0);
            else if (ss == ds) run(0, sb, ss, 1 + ss, db, ds, 3 + db, 0, 0, "R1 same-subarray copy", 0);
            else run(0, sb, ss, 1 + ss, db, ds, 3 + db, 0, 0, "R3 cross-subarray copy", 0);
          end

    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NS; s++) run(1, 0, 0, 0, b, s, 2 + b + s, 0, 0, "R4 zero row", 0);

    for (int n = 0; n < 4; n++) run(2, 0, 0, 0, n & 1, n >> 1, n, n, 8'h5A + n * 17, "R5 fill", 0);

    run(0, 1, 0, 4, 1, 0, 4, 0, 0, "R6 self copy", 0);
    run(3, 0, 1, 2, 1, 0, 5, 0, 0, "R6 kind 3", 0);
    run(0, 0, 1, 3, 1, 1, 0, 0, 0, "R7 busy request ignored", 1);
    run(0, 1, 1, 5, 1, 0, 1, 0, 0, "R3 cross-subarray copy", 1);
    run(2, 0, 0, 0, 1, 1, 2, 3, 8'hC3, "R5 fill", 0);
    run(1, 0, 0, 0, 1, 1, 2, 0, 0, "R4 zero after fill", 0);

    finish_run();
  end
endmodule